// File: doc/BRIEF.md
# Nibble Link Port with Acknowledge Flow Control

This block is a point-to-point link that carries 32-bit words as a stream of 4-bit nibbles. It also sends a link clock alongside the data. A transmitter takes words from the core on a valid/ready handshake and makes the link clock from the core clock. The clock ratio is chosen by a select input. The transmitter launches a new nibble on each rising link-clock edge. At the end of every word it checks the acknowledge line before it starts another word.

A receiver watches the same link clock and captures a nibble on each falling edge. It rebuilds each word with the least significant nibble first and places the word in a two-entry buffer. The core drains that buffer on a second valid/ready handshake. If the buffer has only one free slot left when a word's first nibble arrives, the receiver pulls acknowledge low. This stops the transmitter after the current word.

The enable input takes effect on the transmitter after a fixed two-cycle delay. In this project both ends sit in one top module and run on one core clock. The link wires are brought out so they can be observed.

Top module: `link_port`

## Requirements
- R1: After reset the link clock is high, acknowledge is high, no received word is offered and no transmit word is accepted.
- R2: The transmitter can accept a word only once the enable input has been high for two core cycles. With a word waiting and the link free, acceptance is first offered in the second cycle after enable is sampled high.
- R3: Each high phase and each low phase of the link clock lasts (select + 1) core cycles. The select input is 2 bits, and values 0 to 3 give 1 to 4 cycles.
- R4: When no word is being sent, the link clock stays high and does not toggle. Acceptance of a word is followed by a high link clock.
- R5: A word goes out as 8 nibbles on the 4-bit data bus, least significant nibble (bits 3:0) first. The data bus never changes while the link clock is low.
- R6: The receiver captures a nibble on each falling link-clock edge and rebuilds the word. It offers words to the core in arrival order. An offered word stays valid and unchanged until the core takes it.
- R7: Acknowledge falls only in the cycle after the falling edge of a word's first nibble, and only if the buffer then holds one word (one free entry left). Otherwise acknowledge stays high.
- R8: While acknowledge is low, the transmitter does not start a new word and offers no acceptance.
- R9: Acknowledge returns high only once the buffer is empty and no word is arriving. It is always low while the buffer is full, so the buffer never overflows.
- R10: If another word is waiting and acknowledge is high when a word's last low phase ends, the next word starts at once. Words then start every 16 × (select + 1) core cycles.
- R11: Two cycles after the enable input goes low, no new word is accepted and the link clock stays high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock shared by both ends |
| rst_n | input | 1 | Active-low synchronous reset |
| en_i | input | 1 | Port enable command; takes effect two cycles later |
| div_sel_i | input | 2 | Link-clock phase length select: (value + 1) core cycles per phase |
| tx_data_i | input | 32 | Word to transmit |
| tx_valid_i | input | 1 | A transmit word is offered |
| tx_ready_o | output | 1 | The offered word is taken at this clock edge |
| lclk_o | output | 1 | Link clock sent by the transmitter |
| ldat_o | output | 4 | Link nibble bus |
| lack_o | output | 1 | Acknowledge driven by the receiver |
| rx_data_o | output | 32 | Oldest received word |
| rx_valid_o | output | 1 | A received word is available |
| rx_ready_i | input | 1 | Core takes the received word at this clock edge |

## Verification
The checker watches several rules on every cycle: the nibble bus holds still while the link clock is low, acknowledge can fall only just after a falling link edge, a full buffer always has acknowledge low, acceptance only happens two cycles into an enable, and an offered received word holds until it is taken. Other properties can only be seen across a whole scenario, so the bench runs them. These are the phase lengths for every select value, the least-significant-first order on the wire, the spacing of back-to-back words, and the sequence of a stall. In the stall sequence, two words fill the buffer, a third is held off, one pop still leaves the link stalled, and the second pop releases it. Behaviour under a disabled port is also bench-only.

// File: rtl/link_pkg.sv
package link_pkg;

    // Fixed delay from the enable command to the port becoming active.
    localparam int EN_LAT = 2;

    typedef enum logic [1:0] {
        TX_IDLE = 2'd0,
        TX_HIGH = 2'd1,
        TX_LOW  = 2'd2
    } tx_st_e;

endpackage

// File: rtl/link_enable.sv
module link_enable
    import link_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic en_i,
    output logic on_o
);

    typedef struct packed {
        logic [EN_LAT-1:0] pipe;
    } en_state_t;

    en_state_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.pipe = {st_q.pipe[EN_LAT-2:0], en_i};
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign on_o = st_q.pipe[EN_LAT-1];

endmodule

// File: rtl/link_tx.sv
module link_tx
    import link_pkg::*;
#(
    parameter int WORD_W = 32,
    parameter int NIB_W  = 4,
    parameter int DIV_W  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              port_on_i,
    input  logic [DIV_W-1:0]  div_sel_i,
    input  logic [WORD_W-1:0] word_i,
    input  logic              valid_i,
    output logic              ready_o,
    input  logic              lack_i,
    output logic              lclk_o,
    output logic [NIB_W-1:0]  ldat_o
);

    localparam int NIBS   = WORD_W / NIB_W;
    localparam int NIB_CW = (NIBS > 1) ? $clog2(NIBS) : 1;

    typedef struct packed {
        tx_st_e             st;
        logic [DIV_W-1:0]   cnt;
        logic [NIB_CW-1:0]  nib;
        logic [WORD_W-1:0]  sh;
        logic               lclk;
        logic [NIB_W-1:0]   ldat;
    } tx_state_t;

    tx_state_t st_d, st_q;
    logic      can_start;
    logic      launch;

    always_comb begin
        st_d      = st_q;
        can_start = port_on_i && valid_i && lack_i;
        launch    = 1'b0;

        unique case (st_q.st)
            TX_IDLE: begin
                st_d.lclk = 1'b1;
                if (can_start) launch = 1'b1;
            end
            TX_HIGH: begin
                if (st_q.cnt == div_sel_i) begin
                    st_d.cnt  = '0;
                    st_d.lclk = 1'b0;
                    st_d.st   = TX_LOW;
                end else begin
                    st_d.cnt = st_q.cnt + DIV_W'(1);
                end
            end
            TX_LOW: begin
                if (st_q.cnt == div_sel_i) begin
                    st_d.cnt  = '0;
                    st_d.lclk = 1'b1;
                    if (st_q.nib != NIB_CW'(NIBS - 1)) begin
                        st_d.nib  = st_q.nib + NIB_CW'(1);
                        st_d.ldat = st_q.sh[NIB_W-1:0];
                        st_d.sh   = st_q.sh >> NIB_W;
                        st_d.st   = TX_HIGH;
                    end else if (can_start) begin
                        launch = 1'b1;
                    end else begin
                        st_d.st = TX_IDLE;
                    end
                end else begin
                    st_d.cnt = st_q.cnt + DIV_W'(1);
                end
            end
            default: begin
                st_d.st   = TX_IDLE;
                st_d.lclk = 1'b1;
            end
        endcase

        // A new word puts its first nibble out with the link clock high.
        if (launch) begin
            st_d.st   = TX_HIGH;
            st_d.cnt  = '0;
            st_d.nib  = '0;
            st_d.lclk = 1'b1;
            st_d.ldat = word_i[NIB_W-1:0];
            st_d.sh   = word_i >> NIB_W;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q      <= '0;
            st_q.st   <= TX_IDLE;
            st_q.lclk <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign ready_o = launch;
    assign lclk_o  = st_q.lclk;
    assign ldat_o  = st_q.ldat;

endmodule

// File: rtl/link_rx.sv
module link_rx #(
    parameter int WORD_W = 32,
    parameter int NIB_W  = 4,
    parameter int DEPTH  = 2
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          lclk_i,
    input  logic [NIB_W-1:0]              ldat_i,
    output logic                          lack_o,
    output logic [WORD_W-1:0]             data_o,
    output logic                          valid_o,
    input  logic                          ready_i,
    output logic [$clog2(DEPTH+1)-1:0]    fill_o
);

    localparam int NIBS   = WORD_W / NIB_W;
    localparam int NIB_CW = (NIBS > 1) ? $clog2(NIBS) : 1;
    localparam int ASM_W  = WORD_W - NIB_W;
    localparam int PTR_W  = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W  = $clog2(DEPTH + 1);

    typedef struct packed {
        logic                           lclk_prev;
        logic [NIB_CW-1:0]              nib;
        logic                           busy;
        logic [ASM_W-1:0]               asm_w;
        logic [DEPTH-1:0][WORD_W-1:0]   mem;
        logic [PTR_W-1:0]               wr;
        logic [PTR_W-1:0]               rd;
        logic [CNT_W-1:0]               cnt;
        logic                           lack;
    } rx_state_t;

    rx_state_t st_d, st_q;
    logic      fall;
    logic      push;
    logic      pop;

    always_comb begin
        st_d           = st_q;
        st_d.lclk_prev = lclk_i;
        fall           = st_q.lclk_prev && !lclk_i;
        push           = 1'b0;
        pop            = (st_q.cnt != '0) && ready_i;

        if (fall) begin
            if (st_q.nib == NIB_CW'(NIBS - 1)) begin
                push      = 1'b1;
                st_d.nib  = '0;
                st_d.busy = 1'b0;
                st_d.mem[st_q.wr] = {ldat_i, st_q.asm_w};
                st_d.wr   = (st_q.wr == PTR_W'(DEPTH - 1)) ? '0 : st_q.wr + PTR_W'(1);
            end else begin
                st_d.asm_w = {ldat_i, st_q.asm_w[ASM_W-1:NIB_W]};
                st_d.nib   = st_q.nib + NIB_CW'(1);
                st_d.busy  = 1'b1;
                // First nibble of a word: withdraw acknowledge if one slot is left.
                if (st_q.nib == '0 && st_q.cnt >= CNT_W'(DEPTH - 1))
                    st_d.lack = 1'b0;
            end
        end

        if (pop)
            st_d.rd = (st_q.rd == PTR_W'(DEPTH - 1)) ? '0 : st_q.rd + PTR_W'(1);

        st_d.cnt = st_q.cnt + CNT_W'(push) - CNT_W'(pop);

        // Restore acknowledge once drained and between words.
        if (!st_d.busy && st_d.cnt < CNT_W'(DEPTH - 1))
            st_d.lack = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q           <= '0;
            st_q.lclk_prev <= 1'b1;
            st_q.lack      <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign lack_o  = st_q.lack;
    assign data_o  = st_q.mem[st_q.rd];
    assign valid_o = (st_q.cnt != '0);
    assign fill_o  = st_q.cnt;

endmodule

// File: rtl/link_port.sv
module link_port #(
    parameter int WORD_W = 32,
    parameter int NIB_W  = 4,
    parameter int DIV_W  = 2,
    parameter int DEPTH  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en_i,
    input  logic [DIV_W-1:0]  div_sel_i,
    input  logic [WORD_W-1:0] tx_data_i,
    input  logic              tx_valid_i,
    output logic              tx_ready_o,
    output logic              lclk_o,
    output logic [NIB_W-1:0]  ldat_o,
    output logic              lack_o,
    output logic [WORD_W-1:0] rx_data_o,
    output logic              rx_valid_o,
    input  logic              rx_ready_i
);

    localparam int CNT_W = $clog2(DEPTH + 1);

    logic             port_on;
    logic [CNT_W-1:0] rx_fill;

    link_enable u_en (
        .clk   (clk),
        .rst_n (rst_n),
        .en_i  (en_i),
        .on_o  (port_on)
    );

    link_tx #(
        .WORD_W (WORD_W),
        .NIB_W  (NIB_W),
        .DIV_W  (DIV_W)
    ) u_tx (
        .clk       (clk),
        .rst_n     (rst_n),
        .port_on_i (port_on),
        .div_sel_i (div_sel_i),
        .word_i    (tx_data_i),
        .valid_i   (tx_valid_i),
        .ready_o   (tx_ready_o),
        .lack_i    (lack_o),
        .lclk_o    (lclk_o),
        .ldat_o    (ldat_o)
    );

    link_rx #(
        .WORD_W (WORD_W),
        .NIB_W  (NIB_W),
        .DEPTH  (DEPTH)
    ) u_rx (
        .clk     (clk),
        .rst_n   (rst_n),
        .lclk_i  (lclk_o),
        .ldat_i  (ldat_o),
        .lack_o  (lack_o),
        .data_o  (rx_data_o),
        .valid_o (rx_valid_o),
        .ready_i (rx_ready_i),
        .fill_o  (rx_fill)
    );

endmodule

// File: rtl/link_port_chk.sv
module link_port_chk #(
    parameter int WORD_W = 32,
    parameter int NIB_W  = 4,
    parameter int DEPTH  = 2
) (
    input logic                        clk,
    input logic                        rst_n,
    input logic                        en_i,
    input logic                        tx_ready_o,
    input logic                        lclk_o,
    input logic [NIB_W-1:0]            ldat_o,
    input logic                        lack_o,
    input logic [WORD_W-1:0]           rx_data_o,
    input logic                        rx_valid_o,
    input logic                        rx_ready_i,
    input logic [$clog2(DEPTH+1)-1:0]  fill
);

    // R5: nibble bus holds while the link clock is low
    a_r5_ldat_stable_low: assert property (@(posedge clk) disable iff (!rst_n)
        !lclk_o |-> $stable(ldat_o));

    // R2: acceptance only after enable has been seen two cycles back
    a_r2_enable_latency: assert property (@(posedge clk) disable iff (!rst_n)
        tx_ready_o |-> $past(en_i, 2));

    // R4: an accepted word is followed by a high link clock
    a_r4_start_high: assert property (@(posedge clk) disable iff (!rst_n)
        tx_ready_o |=> lclk_o);

    // R7: acknowledge falls only right after a falling link edge
    a_r7_ack_after_fall: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(lack_o) |-> (!$past(lclk_o) && $past(lclk_o, 2)));

    // R9: a full buffer always has acknowledge withdrawn
    a_r9_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        (fill == ($clog2(DEPTH+1))'(DEPTH)) |-> !lack_o);

    // R6: an offered word holds until taken
    a_r6_hold_rx: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid_o && !rx_ready_i) |=> (rx_valid_o && $stable(rx_data_o)));

endmodule

bind link_port link_port_chk #(
    .WORD_W (WORD_W),
    .NIB_W  (NIB_W),
    .DEPTH  (DEPTH)
) i_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .en_i       (en_i),
    .tx_ready_o (tx_ready_o),
    .lclk_o     (lclk_o),
    .ldat_o     (ldat_o),
    .lack_o     (lack_o),
    .rx_data_o  (rx_data_o),
    .rx_valid_o (rx_valid_o),
    .rx_ready_i (rx_ready_i),
    .fill       (rx_fill)
);

// File: tb/test_link_port.sv
`timescale 1ns/1ps
module test_link_port;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        en;
    logic [1:0]  div_sel;
    logic [31:0] tx_data;
    logic        tx_valid;
    logic        tx_ready;
    logic        lclk;
    logic [3:0]  ldat;
    logic        lack;
    logic [31:0] rx_data;
    logic        rx_valid;
    logic        rx_ready;

    always #10 clk = ~clk;

    link_port i_link_port (
        .clk        (clk),
        .rst_n      (rst_n),
        .en_i       (en),
        .div_sel_i  (div_sel),
        .tx_data_i  (tx_data),
        .tx_valid_i (tx_valid),
        .tx_ready_o (tx_ready),
        .lclk_o     (lclk),
        .ldat_o     (ldat),
        .lack_o     (lack),
        .rx_data_o  (rx_data),
        .rx_valid_o (rx_valid),
        .rx_ready_i (rx_ready)
    );

    // {select, word}
    localparam logic [33:0] VEC [0:7] = '{
        {2'd0, 32'h8765_4321},
        {2'd1, 32'hFEDC_BA98},
        {2'd2, 32'h0000_000F},
        {2'd3, 32'hF000_0000},
        {2'd0, 32'hA5A5_5A5A},
        {2'd3, 32'h1234_5678},
        {2'd1, 32'h0000_0000},
        {2'd2, 32'hFFFF_FFFF}
    };

    int checks = 0;
    int fails  = 0;
    bit done   = 0;
    int cyc    = 0;

    // monitor state
    logic        prev_l = 1'b1;
    int          run = 0;
    bit          from_rise = 0;
    int          last_low = 0;
    int          last_high = 0;
    logic [31:0] mon = '0;
    int          mon_n = 0;
    int          ack_low = 0;
    int          lclk_low = 0;
    logic [31:0] rcv [0:31];
    int          rn = 0;

    always @(posedge clk) cyc <= cyc + 1;

    always @(negedge clk) begin
        if (lclk == prev_l) begin
            run++;
        end else begin
            if (!prev_l) last_low = run;
            else if (from_rise) last_high = run;
            if (prev_l && !lclk) begin
                mon = {ldat, mon[31:4]};
                mon_n++;
            end
            from_rise = lclk;
            run = 1;
        end
        if (tx_ready) from_rise = 0;
        prev_l = lclk;
        if (!lack) ack_low++;
        if (!lclk) lclk_low++;
        if (rx_valid && rx_ready && rn < 32) begin
            rcv[rn] = rx_data;
            rn++;
        end
    end

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    endtask

    task automatic wait_ready(output int t);
        t = -1;
        for (int i = 0; i < 4000; i++) begin
            @(negedge clk);
            if (tx_ready) begin
                t = cyc;
                break;
            end
        end
    endtask

    task automatic wait_rx(input int target);
        for (int i = 0; i < 4000; i++) begin
            @(negedge clk);
            if (rn >= target) break;
        end
    endtask

    initial begin
        #(20ns * 150000);
        checks++;
        fails++;
        $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
        finish_run();
    end

    initial begin
        int t0, t1, base, seen, hi;
        rst_n = 1'b0; en = 1'b0; div_sel = 2'd0;
        tx_data = '0; tx_valid = 1'b0; rx_ready = 1'b1;
        repeat (5) @(posedge clk);
        #1 rst_n = 1'b1;

        // R1 reset state
        @(negedge clk);
        chk(lclk == 1'b1, "R1 lclk", lclk, 1);
        chk(lack == 1'b1, "R1 lack", lack, 1);
        chk(rx_valid == 1'b0, "R1 rx_valid", rx_valid, 0);
        chk(tx_ready == 1'b0, "R1 tx_ready", tx_ready, 0);

        // R2 enable latency
        @(posedge clk); #1;
        tx_data = 32'hCAFE_0001; tx_valid = 1'b1; en = 1'b1;
        @(negedge clk); chk(tx_ready == 1'b0, "R2 cycle0", tx_ready, 0);
        @(negedge clk); chk(tx_ready == 1'b0, "R2 cycle1", tx_ready, 0);
        @(negedge clk); chk(tx_ready == 1'b1, "R2 cycle2", tx_ready, 1);
        @(posedge clk); #1 tx_valid = 1'b0;
        wait_rx(1);
        chk(rn == 1 && rcv[0] == 32'hCAFE_0001, "R2 word", rcv[0], 32'hCAFE_0001);

        // R4 idle link clock stays high
        repeat (10) @(negedge clk);
        lclk_low = 0;
        repeat (30) @(negedge clk);
        chk(lclk_low == 0, "R4 idle", lclk_low, 0);

        // table walk: R3, R5, R6, and R7 (no drop when buffer drains)
        ack_low = 0;
        for (int v = 0; v < 8; v++) begin
            @(posedge clk); #1;
            div_sel = VEC[v][33:32];
            mon_n = 0; last_low = 0; last_high = 0;
            base = rn;
            tx_data = VEC[v][31:0]; tx_valid = 1'b1;
            wait_ready(t0);
            @(posedge clk); #1 tx_valid = 1'b0;
            wait_rx(base + 1);
            repeat (12) @(negedge clk);
            chk(rcv[base] == VEC[v][31:0], "R6 received word", rcv[base], VEC[v][31:0]);
            chk(mon_n == 8 && mon == VEC[v][31:0], "R5 wire order", mon, VEC[v][31:0]);
            chk(last_low == int'(VEC[v][33:32]) + 1, "R3 low phase", last_low, VEC[v][33:32] + 1);
            chk(last_high == int'(VEC[v][33:32]) + 1, "R3 high phase", last_high, VEC[v][33:32] + 1);
        end
        chk(ack_low == 0, "R7 ack stays high", ack_low, 0);

        // R10 back-to-back words, select 1
        @(posedge clk); #1;
        div_sel = 2'd1; base = rn;
        tx_data = 32'h1111_2222; tx_valid = 1'b1;
        wait_ready(t0);
        @(posedge clk); #1 tx_data = 32'h3333_4444;
        wait_ready(t1);
        @(posedge clk); #1 tx_valid = 1'b0;
        chk(t1 - t0 == 32, "R10 spacing", t1 - t0, 32);
        wait_rx(base + 2);
        chk(rcv[base] == 32'h1111_2222 && rcv[base+1] == 32'h3333_4444,
            "R10 words", rcv[base+1], 32'h3333_4444);
        repeat (10) @(negedge clk);

        // R7/R8/R9 flow control with the core not draining
        @(posedge clk); #1;
        div_sel = 2'd0; rx_ready = 1'b0; base = rn;
        tx_data = 32'hAAAA_0000; tx_valid = 1'b1;
        wait_ready(t0);
        @(posedge clk); #1 tx_data = 32'hBBBB_1111;
        wait_ready(t1);
        chk(lack == 1'b1, "R7 ack high before second word", lack, 1);
        @(posedge clk); #1 tx_data = 32'hCCCC_2222;
        seen = 0;
        for (int i = 0; i < 80; i++) begin
            @(negedge clk);
            if (tx_ready) seen++;
        end
        chk(seen == 0, "R8 no start while ack low", seen, 0);
        chk(lack == 1'b0, "R7 ack dropped near full", lack, 0);
        chk(rx_valid == 1'b1, "R6 words held", rx_valid, 1);
        @(posedge clk); #1 rx_ready = 1'b1;
        @(posedge clk); #1 rx_ready = 1'b0;
        seen = 0; hi = 0;
        for (int i = 0; i < 20; i++) begin
            @(negedge clk);
            if (tx_ready) seen++;
            if (lack) hi++;
        end
        chk(hi == 0, "R9 ack low with one stored", hi, 0);
        chk(seen == 0, "R9 still stalled", seen, 0);
        @(posedge clk); #1 rx_ready = 1'b1;
        @(posedge clk); #1 rx_ready = 1'b0;
        wait_ready(t0);
        chk(t0 >= 0, "R9 resume after drain", t0, 1);
        @(posedge clk); #1 tx_valid = 1'b0; rx_ready = 1'b1;
        wait_rx(base + 3);
        chk(rcv[base] == 32'hAAAA_0000, "R6 order 0", rcv[base], 32'hAAAA_0000);
        chk(rcv[base+1] == 32'hBBBB_1111, "R6 order 1", rcv[base+1], 32'hBBBB_1111);
        chk(rcv[base+2] == 32'hCCCC_2222, "R8 held word", rcv[base+2], 32'hCCCC_2222);
        repeat (10) @(negedge clk);

        // R11 disable
        @(posedge clk); #1 en = 1'b0;
        repeat (2) @(posedge clk);
        #1 tx_data = 32'hDEAD_BEEF; tx_valid = 1'b1;
        seen = 0; lclk_low = 0;
        for (int i = 0; i < 40; i++) begin
            @(negedge clk);
            if (tx_ready) seen++;
        end
        chk(seen == 0, "R11 no accept when off", seen, 0);
        chk(lclk_low == 0, "R11 link clock idle", lclk_low, 0);
        tx_valid = 1'b0;

        finish_run();
    end

endmodule